// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

A last-in-first-out store built from 64 data registers and a 6-bit stack pointer. A push request writes the input word onto the stack. A pop request returns the most recently pushed word that has not yet been popped. The popped word appears on a registered output and stays there until the next accepted pop.

The pointer moves in a fixed order. On a push it is incremented first, and the word is then written at the new pointer value. On a pop the word at the current pointer is read first, and the pointer is then decremented. The full flag rises when a push carries the pointer around to zero. As a result, every one of the 64 locations, address 0 included, holds data when the stack is full. The empty flag rises when a pop brings the pointer back to zero.

The block is protected against misuse. A push while full, a pop while empty, and a push and pop in the same cycle all leave the stack, the pointer, the flags and the output unchanged. The reset is asynchronous and active-low. Its release is synchronised inside the block, so the block accepts its first request on the third rising clock edge after the reset pin goes high.

Top module: `reg_lifo`

## Requirements
- R1: During reset and after its release, the empty flag is 1, the full flag is 0 and the data output is all zeros.
- R2: Words are popped in reverse order of pushing: a pop returns the most recent word that was pushed and not yet popped.
- R3: The data output changes only at the clock edge that accepts a pop, and it holds its value in every other cycle.
- R4: The empty flag clears at the edge of any accepted push. It sets at the edge of the pop that removes the last stored word.
- R5: The full flag sets at the edge of the 64th push without an intervening pop. At that point all 64 pushed words are retrievable. Any accepted pop clears the flag.
- R6: A push request while full is ignored. The flags and the output do not change, and the following 64 pops return exactly the words that were stored before the request.
- R7: A pop request while empty is ignored. The output keeps its last value and the flags do not change.
- R8: A cycle with push and pop both asserted changes nothing: the stored words, the flags and the output all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| push_i | input | 1 | Push request for the word on din_i |
| pop_i | input | 1 | Pop request |
| din_i | input | DW (8) | Word to push |
| dout_o | output | DW (8) | Last popped word, registered |
| full_o | output | 1 | All 64 locations hold data |
| empty_o | output | 1 | No location holds data |

## Verification
A behavioural queue model is compared with the ports on every clock cycle under several kinds of traffic:
- A short push-then-pop run separates true reverse ordering from first-in-first-out or fixed-slot behaviour.
- Filling all 64 entries and draining them exposes wrap-around mistakes in the pointer, loss of the word at address 0, and a full flag that rises one push early or late.
- Pushes against a full stack and pops against an empty one show whether the guards hold.
- Cycles with both requests asserted show whether either side leaks through.
- A long mixed pseudo-random sequence covers interleavings near both ends of the stack.

// File: rtl/reg_lifo_pkg.sv
package reg_lifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } lifo_op_e;

  // A request is accepted only when it is alone and the stack can serve it.
  function automatic lifo_op_e decode_op(input logic push, input logic pop,
                                         input logic full, input logic empty);
    lifo_op_e op;
    op = OP_IDLE;
    if (push && !pop && !full)       op = OP_PUSH;
    else if (pop && !push && !empty) op = OP_POP;
    return op;
  endfunction
endpackage

// File: rtl/lifo_rst_sync.sv
module lifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lifo_ptr_ctrl.sv
module lifo_ptr_ctrl
  import reg_lifo_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output lifo_op_e      op_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [AW-1:0] PTR_ONE  = AW'(1);
  localparam logic [AW-1:0] PTR_ZERO = '0;

  logic [AW-1:0] sp_q, sp_d;
  logic          full_q, full_d;
  logic          empty_q, empty_d;
  logic          upd_en;
  lifo_op_e      op;

  always_comb begin
    op      = decode_op(push_i, pop_i, full_q, empty_q);
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    upd_en  = 1'b0;
    unique case (op)
      OP_PUSH: begin
        // pointer advances before the write
        sp_d    = sp_q + PTR_ONE;
        full_d  = (sp_d == PTR_ZERO);
        empty_d = 1'b0;
        upd_en  = 1'b1;
      end
      OP_POP: begin
        // read at current pointer, then step back
        sp_d    = sp_q - PTR_ONE;
        empty_d = (sp_d == PTR_ZERO);
        full_d  = 1'b0;
        upd_en  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (upd_en) begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign op_o      = op;
  assign wr_addr_o = sp_q + PTR_ONE;
  assign rd_addr_o = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];
  logic [DW-1:0] rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          word_en;
    assign word_en = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (word_en) word_q <= wr_data;
    end
    assign words[g] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= words[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/reg_lifo.sv
module reg_lifo
  import reg_lifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          full_o,
  output logic          empty_o
);
  logic          rst_sync_n;
  lifo_op_e      op;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  lifo_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lifo_ptr_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .op_o      (op),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  lifo_store #(.DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (op == OP_PUSH),
    .wr_addr (wr_addr),
    .wr_data (din_i),
    .rd_en   (op == OP_POP),
    .rd_addr (rd_addr),
    .rd_data (dout_o)
  );
endmodule

// File: rtl/reg_lifo_chk.sv
module reg_lifo_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [DW-1:0] dout_o,
  input logic          full_o,
  input logic          empty_o
);
  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  // R4
  push_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> !empty_o);

  // R5
  pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> !full_o);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_i |=> $stable(dout_o));

  // R6
  push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(dout_o)));

  // R7
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(dout_o)));

  // R8
  both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> ($stable(full_o) && $stable(empty_o) && $stable(dout_o)));
endmodule

bind reg_lifo reg_lifo_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .dout_o  (dout_o),
  .full_o  (full_o),
  .empty_o (empty_o)
);

// File: tb/reg_lifo_tb.sv
module reg_lifo_tb;
  localparam int DW = 8;
  localparam int DEPTH = 64;

  logic          clk;
  logic          rst_n;
  logic          push_i;
  logic          pop_i;
  logic [DW-1:0] din_i;
  logic [DW-1:0] dout_o;
  logic          full_o;
  logic          empty_o;

  int tests = 0;
  int fails = 0;
  bit model_on = 0;
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] exp_dout = '0;

  reg_lifo #(.DW(DW), .AW(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .din_i(din_i), .dout_o(dout_o), .full_o(full_o), .empty_o(empty_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model: advances on each rising edge from the sampled inputs
  always @(posedge clk) begin
    if (model_on) begin
      if (push_i && !pop_i && model_q.size() < DEPTH)
        model_q.push_back(din_i);
      else if (pop_i && !push_i && model_q.size() > 0)
        exp_dout = model_q.pop_back();
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      check("R3 dout", int'(dout_o), int'(exp_dout));
      check("R5 full", int'(full_o), int'(model_q.size() == DEPTH));
      check("R4 empty", int'(empty_o), int'(model_q.size() == 0));
    end
  end

  task automatic cyc(input logic p, input logic q, input logic [DW-1:0] d);
    push_i = p; pop_i = q; din_i = d;
    @(posedge clk);
    @(negedge clk);
    push_i = 0; pop_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; push_i = 0; pop_i = 0; din_i = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 empty", int'(empty_o), 1);
    check("R1 full", int'(full_o), 0);
    check("R1 dout", int'(dout_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 empty after release", int'(empty_o), 1);
    check("R1 full after release", int'(full_o), 0);
    model_on = 1;

    // R2: short reverse order
    cyc(1, 0, 8'h11);
    check("R4 empty cleared", int'(empty_o), 0);
    cyc(1, 0, 8'h22);
    cyc(1, 0, 8'h33);
    cyc(0, 1, '0);
    check("R2 first pop", int'(dout_o), 8'h33);
    cyc(0, 0, '0);
    check("R3 hold", int'(dout_o), 8'h33);
    cyc(0, 1, '0);
    check("R2 second pop", int'(dout_o), 8'h22);
    cyc(0, 1, '0);
    check("R2 third pop", int'(dout_o), 8'h11);
    check("R4 empty set", int'(empty_o), 1);

    // R7: pop on empty
    cyc(0, 1, '0);
    check("R7 dout kept", int'(dout_o), 8'h11);
    check("R7 still empty", int'(empty_o), 1);

    // R8: simultaneous requests
    cyc(1, 0, 8'h5A);
    cyc(1, 1, 8'hA5);
    check("R8 dout kept", int'(dout_o), 8'h11);
    cyc(0, 1, '0);
    check("R8 stack unchanged", int'(dout_o), 8'h5A);
    check("R8 empty after single pop", int'(empty_o), 1);

    // R5: fill all 64
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 0, DW'(i * 3 + 1));
      if (i == DEPTH - 2) check("R5 not full at 63", int'(full_o), 0);
    end
    check("R5 full at 64", int'(full_o), 1);
    // R6: push on full
    cyc(1, 0, 8'hEE);
    check("R6 still full", int'(full_o), 1);
    check("R6 dout kept", int'(dout_o), 8'h5A);
    cyc(1, 1, 8'hEF);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cyc(0, 1, '0);
      check("R6 drain order", int'(dout_o), (i * 3 + 1) & 8'hFF);
      if (i == DEPTH - 1) check("R5 full cleared", int'(full_o), 0);
    end
    check("R4 empty after drain", int'(empty_o), 1);

    // mixed traffic, checked per cycle against the model
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[0] | (i < 300 && lfsr[3]), lfsr[1] & ~(i < 300 && lfsr[4]),
            lfsr[15:8]);
      end
    end

    model_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule